// File: doc/BRIEF.md
# Vertical Blanking Data Slicer Scheduler

This block decides, line by line, when each vertical-blanking data slicer of a video decoder may look at the incoming picture. The upstream timing logic supplies a 1-based line number, a field flag, the active video standard and single-cycle start-of-active-video (SAV) and end-of-active-video (EAV) strobes. The block opens a per-slicer enable window on the lines that carry video identification, closed caption or widescreen signalling data for that standard. It keeps one done bit per slicer for the current field.

It also drives a read-ready window. The window spans two consecutive lines late in the blanking interval, once per field. Software or a downstream collector may fetch the sliced results while it is high. Bit recovery itself happens elsewhere; this block only produces the timing.

Top module: `vbi_sched`

## Requirements
- R1: While reset is high and in the cycle after it, every enable, the ready window and all done bits are 0.
- R2: With the 525-line interlaced standard (std_sel 0), the identification enable (id_en) goes high the cycle after the SAV of line 20 when field2 is 0, or of line 283 when field2 is 1. It drops the cycle after the next EAV. The same line number paired with the other field value opens nothing.
- R3: With the 525-line progressive standard (std_sel 2), id_en opens only on line 41, whatever field2 is. Line 20 opens nothing.
- R4: cc_en opens the same way on line 21 (field2 0) or line 284 (field2 1). It does so only with std_sel 0 and comp_in 1, and never with other standards or with comp_in 0.
- R5: wss_en opens on line 23 (field2 0) or line 336 (field2 1). It does so only with std_sel 1 (625-line interlaced) and comp_in 1, and never for 525-line standards.
- R6: For 525-line standards, vbi_rdy rises the cycle after the SAV of line 23 and falls the cycle after the EAV of line 24. In field2 1 of the interlaced standard, lines 286 and 287 are used instead. The progressive standard always uses lines 23 and 24.
- R7: For std_sel 1, vbi_rdy spans from the SAV of line 64 to the EAV of line 65 with field2 0, and from the SAV of line 377 to the EAV of line 378 with field2 1.
- R8: slice_done bit 0 (identification), bit 1 (closed caption) or bit 2 (widescreen) becomes 1 the cycle after the EAV that closes that slicer's enable window. It then holds.
- R9: A new field clears all slice_done bits and any open window in the following cycle. A new field is a change of field2, or an SAV while line_num is 1. When a new field and a closing EAV fall in the same cycle, the clear wins.
- R10: std_sel 3 opens no enable and no ready window, and at most one slicer enable is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| std_sel | input | 2 | 0 525 interlaced, 1 625 interlaced, 2 525 progressive, 3 none |
| field2 | input | 1 | 1 in the second field |
| comp_in | input | 1 | 1 when the source is composite video |
| line_num | input | LINE_W | current 1-based line number |
| sav | input | 1 | one-cycle start of active video strobe |
| eav | input | 1 | one-cycle end of active video strobe |
| id_en | output | 1 | identification slicer window |
| cc_en | output | 1 | closed caption slicer window |
| wss_en | output | 1 | widescreen signalling slicer window |
| vbi_rdy | output | 1 | results may be read |
| slice_done | output | 3 | per-slicer done bits for the current field |

## Verification
Two functions can meet in one cycle. One is the EAV that closes a slicer window and would set its done bit. The other is a field change that clears all done bits. The bench provokes this by toggling field2 in the same cycle as the EAV that ends line 20. It then checks that the identification done bit stays 0, because the clear has priority. A behavioural model compares every output on every cycle. That comparison also judges the quiet lines around each target line and the two-line ready windows.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

    typedef enum logic [1:0] {
        STD_525I = 2'd0,
        STD_625I = 2'd1,
        STD_525P = 2'd2,
        STD_NONE = 2'd3
    } vstd_e;

    localparam int N_SLICE = 3;
    localparam int SL_ID   = 0;
    localparam int SL_CC   = 1;
    localparam int SL_WSS  = 2;

    typedef struct packed {
        logic first;
        logic last;
    } rdy_hit_t;

    // Target line of a slicer, 0 when the slicer is idle for this setting.
    function automatic int slice_line(vstd_e s, int slc, logic f2, logic comp);
        int ln;
        ln = 0;
        case (s)
            STD_525I: begin
                if (slc == SL_ID)             ln = f2 ? 283 : 20;
                if (slc == SL_CC && comp)     ln = f2 ? 284 : 21;
            end
            STD_625I: begin
                if (slc == SL_WSS && comp)    ln = f2 ? 336 : 23;
            end
            STD_525P: begin
                if (slc == SL_ID)             ln = 41;
            end
            default: ln = 0;
        endcase
        return ln;
    endfunction

    // First line of the ready window, 0 when none.
    function automatic int rdy_line(vstd_e s, logic f2);
        case (s)
            STD_525I: return f2 ? 286 : 23;
            STD_625I: return f2 ? 377 : 64;
            STD_525P: return 23;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/vbi_line_decode.sv
module vbi_line_decode
    import vbi_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  vstd_e               std_sel,
    input  logic                field2,
    input  logic                comp_in,
    input  logic [LINE_W-1:0]   line_num,
    output logic [N_SLICE-1:0]  slice_hit,
    output rdy_hit_t            rdy_hit
);
    int cur_line;
    int rdy_first;

    assign cur_line  = int'(line_num);
    assign rdy_first = rdy_line(std_sel, field2);

    for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
        int tgt;
        assign tgt          = slice_line(std_sel, g, field2, comp_in);
        assign slice_hit[g] = (tgt != 0) && (cur_line == tgt);
    end

    always_comb begin
        rdy_hit.first = (rdy_first != 0) && (cur_line == rdy_first);
        rdy_hit.last  = (rdy_first != 0) && (cur_line == rdy_first + 1);
    end
endmodule

// File: rtl/vbi_field_track.sv
module vbi_field_track #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              field2,
    input  logic              sav,
    input  logic [LINE_W-1:0] line_num,
    output logic              new_field
);
    localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

    logic field_q;

    // Plain sample of the field flag, loaded in reset as well.
    always_ff @(posedge clk) begin
        field_q <= field2;
    end

    assign new_field = (field2 != field_q) || (sav && line_num == FIRST_LINE);
endmodule

// File: rtl/vbi_win.sv
module vbi_win #(
    parameter bit HAS_DONE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic new_field,
    input  logic open_i,
    input  logic close_i,
    output logic win_o,
    output logic done_o
);
    always_ff @(posedge clk) begin
        if (rst || new_field)  win_o <= 1'b0;
        else if (open_i)       win_o <= 1'b1;
        else if (close_i)      win_o <= 1'b0;
    end

    if (HAS_DONE) begin : g_done
        logic done_q;
        always_ff @(posedge clk) begin
            if (rst || new_field)      done_q <= 1'b0;
            else if (close_i && win_o) done_q <= 1'b1;
        end
        assign done_o = done_q;
    end else begin : g_nodone
        assign done_o = 1'b0;
    end
endmodule

// File: rtl/vbi_sched.sv
module vbi_sched
    import vbi_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        std_sel,
    input  logic              field2,
    input  logic              comp_in,
    input  logic [LINE_W-1:0] line_num,
    input  logic              sav,
    input  logic              eav,
    output logic              id_en,
    output logic              cc_en,
    output logic              wss_en,
    output logic              vbi_rdy,
    output logic [2:0]        slice_done
);
    logic [N_SLICE-1:0] slice_hit;
    logic [N_SLICE-1:0] win;
    logic [N_SLICE-1:0] done;
    rdy_hit_t           rdy_hit;
    logic               new_field;
    logic               rdy_unused;

    vbi_line_decode #(.LINE_W(LINE_W)) u_dec (
        .std_sel   (vstd_e'(std_sel)),
        .field2    (field2),
        .comp_in   (comp_in),
        .line_num  (line_num),
        .slice_hit (slice_hit),
        .rdy_hit   (rdy_hit)
    );

    vbi_field_track #(.LINE_W(LINE_W)) u_fld (
        .clk       (clk),
        .field2    (field2),
        .sav       (sav),
        .line_num  (line_num),
        .new_field (new_field)
    );

    for (genvar g = 0; g < N_SLICE; g++) begin : g_slicer
        vbi_win #(.HAS_DONE(1'b1)) u_win (
            .clk       (clk),
            .rst       (rst),
            .new_field (new_field),
            .open_i    (sav && slice_hit[g]),
            .close_i   (eav),
            .win_o     (win[g]),
            .done_o    (done[g])
        );
    end

    vbi_win #(.HAS_DONE(1'b0)) u_rdy (
        .clk       (clk),
        .rst       (rst),
        .new_field (new_field),
        .open_i    (sav && rdy_hit.first),
        .close_i   (eav && rdy_hit.last),
        .win_o     (vbi_rdy),
        .done_o    (rdy_unused)
    );

    assign id_en      = win[SL_ID];
    assign cc_en      = win[SL_CC];
    assign wss_en     = win[SL_WSS];
    assign slice_done = done;
endmodule

// File: rtl/vbi_sched_chk.sv
module vbi_sched_chk
    import vbi_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        std_sel,
    input logic              field2,
    input logic              comp_in,
    input logic [LINE_W-1:0] line_num,
    input logic              sav,
    input logic              eav,
    input logic              id_en,
    input logic              cc_en,
    input logic              wss_en,
    input logic              vbi_rdy,
    input logic [2:0]        slice_done
);
    a_r2_id_open: assert property (@(posedge clk) disable iff (rst)
        $rose(id_en) |-> $past(sav) &&
            ($past(std_sel) == 2'(STD_525I) || $past(std_sel) == 2'(STD_525P)));

    a_r4_cc_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(cc_en) |-> $past(sav) && $past(comp_in) && $past(std_sel) == 2'(STD_525I) &&
            ($past(line_num) == LINE_W'(21) || $past(line_num) == LINE_W'(284)));

    a_r5_wss_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(wss_en) |-> $past(sav) && $past(comp_in) && $past(std_sel) == 2'(STD_625I) &&
            ($past(line_num) == LINE_W'(23) || $past(line_num) == LINE_W'(336)));

    a_r6_rdy_open: assert property (@(posedge clk) disable iff (rst)
        $rose(vbi_rdy) |-> $past(sav) && $past(std_sel) != 2'(STD_NONE));

    a_r8_done_id: assert property (@(posedge clk) disable iff (rst)
        $rose(slice_done[0]) |-> $past(eav) && $past(id_en));

    a_r8_done_cc: assert property (@(posedge clk) disable iff (rst)
        $rose(slice_done[1]) |-> $past(eav) && $past(cc_en));

    a_r8_done_wss: assert property (@(posedge clk) disable iff (rst)
        $rose(slice_done[2]) |-> $past(eav) && $past(wss_en));

    a_r9_field_clear: assert property (@(posedge clk) disable iff (rst)
        (field2 != $past(field2)) |=> (slice_done == 3'b000));

    a_r10_one_slicer: assert property (@(posedge clk) disable iff (rst)
        $onehot0({id_en, cc_en, wss_en}));
endmodule

bind vbi_sched vbi_sched_chk #(.LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst(rst), .std_sel(std_sel), .field2(field2), .comp_in(comp_in),
    .line_num(line_num), .sav(sav), .eav(eav), .id_en(id_en), .cc_en(cc_en),
    .wss_en(wss_en), .vbi_rdy(vbi_rdy), .slice_done(slice_done)
);

// File: tb/sim_vbi_sched.sv
`timescale 1ns/1ps
module sim_vbi_sched;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    std_sel = 2'd0;
    logic          field2 = 1'b0;
    logic          comp_in = 1'b1;
    logic [LW-1:0] line_num = '0;
    logic          sav = 1'b0;
    logic          eav = 1'b0;
    logic          id_en, cc_en, wss_en, vbi_rdy;
    logic [2:0]    slice_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vbi_sched #(.LINE_W(LW)) u0 (
        .clk(clk), .rst(rst), .std_sel(std_sel), .field2(field2), .comp_in(comp_in),
        .line_num(line_num), .sav(sav), .eav(eav), .id_en(id_en), .cc_en(cc_en),
        .wss_en(wss_en), .vbi_rdy(vbi_rdy), .slice_done(slice_done)
    );

    // ---------------- behavioural reference model ----------------
    bit m_win[3];
    bit m_done[3];
    bit m_rdy;
    bit m_fld;
    bit m_live = 1'b0;

    // Target line from the requirement text; 0 = none.
    function automatic int want_line(int s, int std, bit f2, bit comp);
        if (std == 0 && s == 0) return f2 ? 283 : 20;
        if (std == 0 && s == 1 && comp) return f2 ? 284 : 21;
        if (std == 1 && s == 2 && comp) return f2 ? 336 : 23;
        if (std == 2 && s == 0) return 41;
        return 0;
    endfunction

    function automatic int want_rdy(int std, bit f2);
        if (std == 0) return f2 ? 286 : 23;
        if (std == 1) return f2 ? 377 : 64;
        if (std == 2) return 23;
        return 0;
    endfunction

    always @(posedge clk) begin
        int ln, rl;
        bit nf;
        ln = int'(line_num);
        if (rst) begin
            for (int i = 0; i < 3; i++) begin m_win[i] = 0; m_done[i] = 0; end
            m_rdy = 0;
        end else begin
            nf = (field2 != m_fld) || (sav && ln == 1);
            for (int i = 0; i < 3; i++) begin
                int t;
                t = want_line(i, int'(std_sel), field2, comp_in);
                if (nf) m_done[i] = 0;
                else if (eav && m_win[i]) m_done[i] = 1;
                if (nf) m_win[i] = 0;
                else if (sav && t != 0 && ln == t) m_win[i] = 1;
                else if (eav) m_win[i] = 0;
            end
            rl = want_rdy(int'(std_sel), field2);
            if (nf) m_rdy = 0;
            else if (sav && rl != 0 && ln == rl) m_rdy = 1;
            else if (eav && rl != 0 && ln == rl + 1) m_rdy = 0;
        end
        m_fld = field2;
        m_live = 1'b1;
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_live && !finished) begin
            check(id_en == m_win[0], "R2 R3 id_en", id_en, m_win[0]);
            check(cc_en == m_win[1], "R4 cc_en", cc_en, m_win[1]);
            check(wss_en == m_win[2], "R5 wss_en", wss_en, m_win[2]);
            check(vbi_rdy == m_rdy, "R6 R7 vbi_rdy", vbi_rdy, m_rdy);
            check(slice_done == {m_done[2], m_done[1], m_done[0]}, "R8 R9 slice_done",
                  slice_done, {m_done[2], m_done[1], m_done[0]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_line(int ln);
        @(negedge clk); line_num = LW'(ln); sav = 1'b1;
        @(negedge clk); sav = 1'b0;
        repeat (2) @(negedge clk);
        eav = 1'b1;
        @(negedge clk); eav = 1'b0;
    endtask

    task automatic run_lines(int a, int b);
        for (int l = a; l <= b; l++) run_line(l);
    endtask

    task automatic set_mode(int std, bit comp, bit f2);
        @(negedge clk); std_sel = 2'(std); comp_in = comp; field2 = f2;
    endtask

    task automatic expect_done(logic [2:0] exp, string tag);
        @(negedge clk);
        check(slice_done == exp, tag, slice_done, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({id_en, cc_en, wss_en, vbi_rdy, slice_done} == 7'd0, "R1 reset",
              {id_en, cc_en, wss_en, vbi_rdy, slice_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({id_en, cc_en, wss_en, vbi_rdy, slice_done} == 7'd0, "R1 after reset",
              {id_en, cc_en, wss_en, vbi_rdy, slice_done}, 0);

        // 525 interlaced, composite: both fields
        set_mode(0, 1, 0);
        run_lines(1, 26);
        expect_done(3'b011, "R2 R4 R8 field1 525i");
        set_mode(0, 1, 1);
        run_lines(263, 270);
        expect_done(3'b000, "R9 field change clears");
        run_lines(271, 290);
        expect_done(3'b011, "R2 R4 R8 field2 525i");
        check(vbi_rdy == 1'b0, "R6 ready closed", vbi_rdy, 0);

        // 525 interlaced, component: no closed caption
        set_mode(0, 0, 0);
        run_lines(1, 26);
        expect_done(3'b001, "R4 no cc without composite");

        // wrong field for line 20
        set_mode(0, 1, 1);
        run_lines(1, 1);
        run_lines(20, 21);
        expect_done(3'b000, "R2 line 20 in field2 ignored");

        // 625 interlaced
        set_mode(1, 1, 0);
        run_lines(1, 66);
        expect_done(3'b100, "R5 R7 field1 625i");
        set_mode(1, 1, 1);
        run_lines(313, 380);
        expect_done(3'b100, "R5 R7 field2 625i");

        // 525 progressive
        set_mode(2, 1, 0);
        run_lines(1, 30);
        expect_done(3'b000, "R3 line 20 ignored in progressive");
        run_lines(31, 45);
        expect_done(3'b001, "R3 line 41");
        set_mode(2, 1, 1);
        run_lines(1, 45);
        expect_done(3'b001, "R3 R6 field flag ignored");

        // no standard
        set_mode(3, 1, 0);
        run_lines(1, 70);
        expect_done(3'b000, "R10 no standard");
        check(vbi_rdy == 1'b0, "R10 no ready", vbi_rdy, 0);

        // collision: closing EAV of line 20 with a field change
        set_mode(0, 1, 0);
        run_lines(1, 19);
        @(negedge clk); line_num = LW'(20); sav = 1'b1;
        @(negedge clk); sav = 1'b0;
        @(negedge clk);
        check(id_en == 1'b1, "R2 window open before collision", id_en, 1);
        @(negedge clk); eav = 1'b1; field2 = 1'b1;
        @(negedge clk); eav = 1'b0;
        check(slice_done == 3'b000, "R9 clear wins over set", slice_done, 0);
        check(id_en == 1'b0, "R9 window closed", id_en, 0);
        run_lines(263, 265);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule